// File: doc/BRIEF.md
# Single-Wire Debug Link Bit Engine

This block is the target-side bit layer of a debug link that runs over one shared open-drain wire. The remote host sets the pace of every bit: it pulls the wire low to open a bit window, and the target either samples the wire or drives its answer inside that window. The target counts time in units of a slow target clock, formed here as one enable pulse in every eight cycles of the fast input clock. Bits travel most significant first, and a transfer carries 8 or 16 bits.

A command layer above this block starts a receive with `rx_start` or a transmit with `tx_load`. It then waits for `rx_valid` or `tx_done`. If the host goes quiet in the middle of a transfer, the block aborts with `timeout` and returns to idle. The pad is controlled through two signals. `pad_oe` enables the driver. `pad_hi` selects between driving low and a brief driven-high speedup pulse. With the driver off, the wire is left to its pull-up.

Top module: `sdb_phy`

## Requirements
- R1: After synchronous reset, `pad_oe`, `busy`, `rx_valid`, `tx_done` and `timeout` are all 0.
- R2: One target clock is one `clk` cycle in eight. Every drive interval on the pad lasts a whole number of target clocks (a multiple of 8 `clk` cycles).
- R3: `rx_start` in idle begins a receive. `rx_word` = 0 selects 8 bits and 1 selects 16 bits. Bits are assembled most significant first. After the last bit, `rx_valid` pulses for one cycle and `busy` drops. `rx_data` holds the result right-aligned, with bits 15:8 zero in 8-bit mode.
- R4: During a receive, the wire is sampled 10 target clocks after each detected host falling edge. Low gives 0 and high gives 1.
- R5: During a transmit, a 0 bit drives the wire low (`pad_oe`=1, `pad_hi`=0) from the detected edge for exactly 13 target clocks (104 `clk` cycles). No high drive occurs in that bit.
- R6: During a transmit, a 1 bit never drives low. It drives high (`pad_oe`=1, `pad_hi`=1) for exactly one target clock, while the bit counter holds 7.
- R7: `tx_load` in idle begins a transmit of `tx_data[15:0]` (`tx_word`=1) or `tx_data[7:0]` (`tx_word`=0), most significant bit first. A one-cycle `tx_done` follows the last bit.
- R8: Falling edges within the first 15 target clocks after a detected edge are ignored. The next bit can start from the 16th.
- R9: During a transfer, if 512 target clocks pass after the last detected edge (or after the start strobe) with no new edge, `timeout` pulses once. The block then returns to idle and issues no `rx_valid` or `tx_done`.
- R10: A gap between host edges shorter than 512 target clocks does not abort the transfer.
- R11: `rx_start` and `tx_load` while `busy` are ignored. If both arrive together in idle, the transmit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; target clock is one enable in 8 cycles |
| srst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw level of the shared debug wire |
| pad_oe | output | 1 | Pad driver enable |
| pad_hi | output | 1 | Level driven when enabled (1 only during a speedup pulse) |
| rx_start | input | 1 | Strobe: begin a receive |
| rx_word | input | 1 | Receive length select: 0 = 8 bits, 1 = 16 bits |
| rx_data | output | 16 | Received value, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when a receive completes |
| tx_load | input | 1 | Strobe: begin a transmit |
| tx_word | input | 1 | Transmit length select: 0 = 8 bits, 1 = 16 bits |
| tx_data | input | 16 | Value to transmit |
| tx_done | output | 1 | One-cycle pulse when a transmit completes |
| busy | output | 1 | A transfer is in progress |
| timeout | output | 1 | One-cycle pulse when a transfer aborts for lack of host edges |

## Verification
The bench sweeps host edge phase against the divide-by-8 enable, because a design that timed from the raw edge instead of the detected one would break only at some phases. It adds a one-target-clock glitch late in each bit. A design that reopened edge detection too early would take the glitch as an extra bit and shift the received value. It measures each transmitted bit's low and high drive in clock cycles, which catches a wrong hold length or a speedup pulse that is stretched or misplaced. It also places the quiet interval just inside and well beyond the abort limit. A design with an off-by-several counter would either drop a valid slow transfer or report `timeout` outside the expected window.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    // Widest transfer; the short form carries half of it.
    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;
    localparam int NBIT_W = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } link_state_e;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } link_dir_e;

    typedef struct packed {
        logic oe;
        logic hi;
    } pad_drive_t;

    function automatic logic [NBIT_W-1:0] bits_for(input logic word_sel);
        return word_sel ? NBIT_W'(DATA_W) : NBIT_W'(HALF_W);
    endfunction

endpackage

// File: rtl/sdb_tick_gen.sv
module sdb_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic srst,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (srst)
            div_q <= '0;
        else if (div_q == DW'(DIV - 1))
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == DW'(DIV - 1));

    // R2: enables are isolated single-cycle pulses
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (srst)
        tick |=> !tick);

endmodule

// File: rtl/sdb_edge_det.sv
module sdb_edge_det (
    input  logic clk,
    input  logic srst,
    input  logic tick,
    input  logic line_raw,
    output logic line_now,
    output logic fall
);
    logic sync1_q, sync2_q, prev_q;

    // Two-flop synchroniser at the fast clock; the previous level is
    // captured only on target-clock enables, so edges are seen per target clock.
    always_ff @(posedge clk) begin
        if (srst) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync1_q <= line_raw;
            sync2_q <= sync1_q;
            if (tick)
                prev_q <= sync2_q;
        end
    end

    assign line_now = sync2_q;
    assign fall     = tick & prev_q & ~sync2_q;

endmodule

// File: rtl/sdb_shifter.sv
module sdb_shifter
    import sdb_pkg::*;
(
    input  logic              clk,
    input  logic              srst,
    input  logic              load_tx,
    input  logic              tx_word,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              clear,
    input  logic              shift_in,
    input  logic              in_bit,
    input  logic              shift_out,
    input  logic              cap_word,
    output logic              out_bit,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] load_val;

    // Short transfers are left-aligned so the MSB is always at the top.
    assign load_val = tx_word ? tx_data : {tx_data[HALF_W-1:0], {HALF_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (srst)
            sh_q <= '0;
        else if (load_tx)
            sh_q <= load_val;
        else if (clear)
            sh_q <= '0;
        else if (shift_in)
            sh_q <= {sh_q[DATA_W-2:0], in_bit};
        else if (shift_out)
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end

    assign out_bit = sh_q[DATA_W-1];
    assign rx_data = cap_word ? sh_q : {{HALF_W{1'b0}}, sh_q[HALF_W-1:0]};

endmodule

// File: rtl/sdb_bit_ctrl.sv
module sdb_bit_ctrl
    import sdb_pkg::*;
#(
    parameter int BIT_TC      = 16,
    parameter int SAMPLE_TC   = 10,
    parameter int ZERO_END_TC = 13,
    parameter int PULSE_TC    = 7,
    parameter int TIMEOUT_TC  = 512
) (
    input  logic       clk,
    input  logic       srst,
    input  logic       tick,
    input  logic       fall,
    input  logic       rx_start,
    input  logic       rx_word,
    input  logic       tx_load,
    input  logic       tx_word,
    input  logic       out_bit,
    output logic       load_tx,
    output logic       clear,
    output logic       shift_in,
    output logic       shift_out,
    output logic       word_sel,
    output pad_drive_t drive,
    output logic       busy,
    output logic       rx_valid,
    output logic       tx_done,
    output logic       timeout
);
    localparam int CW = $clog2(BIT_TC + 1);
    localparam int TW = $clog2(TIMEOUT_TC + BIT_TC + 1);

    link_state_e        st_q;
    link_dir_e          dir_q;
    logic [NBIT_W-1:0]  left_q;
    logic [CW-1:0]      cnt_q;
    logic [TW-1:0]      idle_q;

    logic in_bit_win, bit_end, last_bit, quiet_end;

    assign in_bit_win = (st_q == ST_ACTIVE) && tick;
    assign bit_end    = in_bit_win && (cnt_q == CW'(BIT_TC - 1));
    assign last_bit   = (left_q == NBIT_W'(1));
    assign quiet_end  = (st_q == ST_ARMED) && tick && !fall &&
                        (idle_q == TW'(TIMEOUT_TC - 1));

    assign load_tx   = (st_q == ST_IDLE) && tx_load;
    assign clear     = (st_q == ST_IDLE) && rx_start && !tx_load;
    assign shift_in  = in_bit_win && (dir_q == DIR_RX) && (cnt_q == CW'(SAMPLE_TC));
    assign shift_out = bit_end && (dir_q == DIR_TX);
    assign busy      = (st_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q     <= ST_IDLE;
            dir_q    <= DIR_RX;
            word_sel <= 1'b0;
            left_q   <= '0;
            cnt_q    <= '0;
            idle_q   <= '0;
            rx_valid <= 1'b0;
            tx_done  <= 1'b0;
            timeout  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_done  <= 1'b0;
            timeout  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (tx_load || rx_start) begin
                        st_q     <= ST_ARMED;
                        dir_q    <= tx_load ? DIR_TX : DIR_RX;
                        word_sel <= tx_load ? tx_word : rx_word;
                        left_q   <= bits_for(tx_load ? tx_word : rx_word);
                        cnt_q    <= '0;
                        idle_q   <= '0;
                    end
                end
                ST_ARMED: begin
                    if (tick) begin
                        if (fall) begin
                            st_q   <= ST_ACTIVE;
                            cnt_q  <= CW'(1);
                            idle_q <= '0;
                        end else if (quiet_end) begin
                            st_q    <= ST_IDLE;
                            timeout <= 1'b1;
                        end else begin
                            idle_q <= idle_q + 1'b1;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (tick) begin
                        idle_q <= idle_q + 1'b1;
                        if (bit_end) begin
                            cnt_q  <= '0;
                            left_q <= left_q - 1'b1;
                            if (last_bit) begin
                                st_q <= ST_IDLE;
                                if (dir_q == DIR_RX)
                                    rx_valid <= 1'b1;
                                else
                                    tx_done <= 1'b1;
                            end else begin
                                st_q <= ST_ARMED;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Pad drive: a zero holds the wire low through ZERO_END_TC, a one
    // gets a single speedup target clock.
    always_comb begin
        drive = '{oe: 1'b0, hi: 1'b0};
        if (st_q == ST_ACTIVE && dir_q == DIR_TX) begin
            if (!out_bit && cnt_q <= CW'(ZERO_END_TC))
                drive = '{oe: 1'b1, hi: 1'b0};
            else if (out_bit && cnt_q == CW'(PULSE_TC))
                drive = '{oe: 1'b1, hi: 1'b1};
        end
    end

    // R3: completion of a receive is a single-cycle pulse with idle following
    p_rx_valid_pulse_r3: assert property (@(posedge clk) disable iff (srst)
        rx_valid |-> !busy ##1 !rx_valid);

    // R7: completion of a transmit is a single-cycle pulse
    p_tx_done_pulse_r7: assert property (@(posedge clk) disable iff (srst)
        tx_done |=> !tx_done);

    // R8: inside a bit window the controller stays in the window
    p_bit_hold_r8: assert property (@(posedge clk) disable iff (srst)
        (in_bit_win && cnt_q < CW'(BIT_TC - 1)) |=> (st_q == ST_ACTIVE));

    // R9: an abort never coincides with a completion and leaves the block idle
    p_timeout_quiet_r9: assert property (@(posedge clk) disable iff (srst)
        timeout |-> (!rx_valid && !tx_done && !busy));

    // R11: a start strobe while busy leaves direction unchanged
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (srst)
        (busy && (tx_load || rx_start)) |=> $stable(dir_q));

endmodule

// File: rtl/sdb_phy.sv
module sdb_phy
    import sdb_pkg::*;
#(
    parameter int DIV         = 8,
    parameter int BIT_TC      = 16,
    parameter int SAMPLE_TC   = 10,
    parameter int ZERO_END_TC = 13,
    parameter int PULSE_TC    = 7,
    parameter int TIMEOUT_TC  = 512
) (
    input  logic        clk,
    input  logic        srst,
    input  logic        line_in,
    output logic        pad_oe,
    output logic        pad_hi,
    input  logic        rx_start,
    input  logic        rx_word,
    output logic [15:0] rx_data,
    output logic        rx_valid,
    input  logic        tx_load,
    input  logic        tx_word,
    input  logic [15:0] tx_data,
    output logic        tx_done,
    output logic        busy,
    output logic        timeout
);
    localparam int RUN_W = $clog2(DIV * (ZERO_END_TC + 2) + 1);

    logic       tick, line_now, fall;
    logic       load_tx, clear, shift_in, shift_out, word_sel, out_bit;
    pad_drive_t drive;

    sdb_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .srst (srst),
        .tick (tick)
    );

    sdb_edge_det u_edge (
        .clk      (clk),
        .srst     (srst),
        .tick     (tick),
        .line_raw (line_in),
        .line_now (line_now),
        .fall     (fall)
    );

    sdb_bit_ctrl #(
        .BIT_TC      (BIT_TC),
        .SAMPLE_TC   (SAMPLE_TC),
        .ZERO_END_TC (ZERO_END_TC),
        .PULSE_TC    (PULSE_TC),
        .TIMEOUT_TC  (TIMEOUT_TC)
    ) u_ctrl (
        .clk       (clk),
        .srst      (srst),
        .tick      (tick),
        .fall      (fall),
        .rx_start  (rx_start),
        .rx_word   (rx_word),
        .tx_load   (tx_load),
        .tx_word   (tx_word),
        .out_bit   (out_bit),
        .load_tx   (load_tx),
        .clear     (clear),
        .shift_in  (shift_in),
        .shift_out (shift_out),
        .word_sel  (word_sel),
        .drive     (drive),
        .busy      (busy),
        .rx_valid  (rx_valid),
        .tx_done   (tx_done),
        .timeout   (timeout)
    );

    sdb_shifter u_shift (
        .clk       (clk),
        .srst      (srst),
        .load_tx   (load_tx),
        .tx_word   (tx_word),
        .tx_data   (tx_data),
        .clear     (clear),
        .shift_in  (shift_in),
        .in_bit    (line_now),
        .shift_out (shift_out),
        .cap_word  (word_sel),
        .out_bit   (out_bit),
        .rx_data   (rx_data)
    );

    assign pad_oe = drive.oe;
    assign pad_hi = drive.hi;

    // Run-length counters of the two drive kinds, for the bounds below.
    logic [RUN_W-1:0] hi_run_q, lo_run_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= (pad_oe && pad_hi)  ? hi_run_q + 1'b1 : '0;
            lo_run_q <= (pad_oe && !pad_hi) ? lo_run_q + 1'b1 : '0;
        end
    end

    // R6: the speedup pulse never lasts longer than one target clock
    p_hi_short_r6: assert property (@(posedge clk) disable iff (srst)
        hi_run_q <= RUN_W'(DIV));

    // R5: a low drive never exceeds the zero-bit hold
    p_lo_short_r5: assert property (@(posedge clk) disable iff (srst)
        lo_run_q <= RUN_W'(DIV * ZERO_END_TC));

    // R1: the pad is released whenever no transfer is in progress
    p_idle_release_r1: assert property (@(posedge clk) disable iff (srst)
        (!busy && !$past(busy)) |-> !pad_oe);

endmodule

// File: tb/tb_sdb_phy.sv
module tb_sdb_phy;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        srst     = 1'b1;
    logic        host_low = 1'b0;
    logic        rx_start = 1'b0, rx_word = 1'b0, tx_load = 1'b0, tx_word = 1'b0;
    logic [15:0] tx_data  = '0;
    logic        pad_oe, pad_hi, rx_valid, tx_done, busy, timeout;
    logic [15:0] rx_data;
    logic        line_in;

    // Open-drain wire: low if anyone pulls low, otherwise high.
    assign line_in = !(host_low || (pad_oe && !pad_hi));

    sdb_phy dut (
        .clk      (clk),
        .srst     (srst),
        .line_in  (line_in),
        .pad_oe   (pad_oe),
        .pad_hi   (pad_hi),
        .rx_start (rx_start),
        .rx_word  (rx_word),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .tx_load  (tx_load),
        .tx_word  (tx_word),
        .tx_data  (tx_data),
        .tx_done  (tx_done),
        .busy     (busy),
        .timeout  (timeout)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0, n_rxv = 0, n_txd = 0, n_to = 0, to_cyc = 0, oe_clks = 0, edge_cyc = 0;
    logic [15:0] cap = '0;
    bit finished = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rx_valid) begin
            n_rxv <= n_rxv + 1;
            cap   <= rx_data;
        end
        if (tx_done) n_txd <= n_txd + 1;
        if (timeout) begin
            n_to   <= n_to + 1;
            to_cyc <= cyc;
        end
        if (pad_oe) oe_clks <= oe_clks + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Host opens a bit and sends a value to the target.
    task automatic host_rx_bit(input bit b, input int period, input bit glitch);
        int low_len;
        low_len = b ? 32 : 104;
        @(negedge clk);
        host_low = 1'b1;
        edge_cyc = cyc;
        repeat (low_len) @(negedge clk);
        host_low = 1'b0;
        if (glitch) begin
            repeat (112 - low_len) @(negedge clk);
            host_low = 1'b1;
            repeat (8) @(negedge clk);
            host_low = 1'b0;
            repeat (period * 8 - 121) @(negedge clk);
        end else begin
            repeat (period * 8 - low_len - 1) @(negedge clk);
        end
    endtask

    // Host opens a bit and reads the target's answer; drive lengths are measured.
    task automatic host_tx_bit(input int period, output bit b, output int lo, output int hi);
        lo = 0;
        hi = 0;
        b  = 1'b0;
        @(negedge clk);
        host_low = 1'b1;
        for (int k = 1; k <= period * 8; k++) begin
            @(negedge clk);
            if (k == 16) host_low = 1'b0;
            if (k == 80) b = line_in;
            if (pad_oe && !pad_hi) lo++;
            if (pad_oe && pad_hi) hi++;
        end
    endtask

    task automatic rx_xfer(input bit word, input logic [15:0] val, input int period,
                           input int phase, input bit glitch, input int gap, input bit poke);
        int nb, rv0, to0, oe0;
        logic [15:0] expv;
        nb  = word ? 16 : 8;
        rv0 = n_rxv;
        to0 = n_to;
        repeat (phase) @(negedge clk);
        rx_word  = word;
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        oe0 = oe_clks;
        repeat (3) @(negedge clk);
        for (int i = nb - 1; i >= 0; i--) begin
            host_rx_bit(val[i], period, glitch);
            if (i == nb - 3 && gap > 0) repeat (gap) @(negedge clk);
            if (i == nb - 2 && poke) begin
                tx_word = 1'b1;
                tx_data = 16'hFFFF;
                tx_load = 1'b1;
                @(negedge clk);
                tx_load = 1'b0;
            end
        end
        repeat (4) @(negedge clk);
        expv = word ? val : {8'h00, val[7:0]};
        check(n_rxv == rv0 + 1, "R3", "rx_valid pulses", n_rxv - rv0, 1);
        check(cap == expv, "R3 R4", "received value", int'(cap), int'(expv));
        check(!busy, "R3", "busy after receive", int'(busy), 0);
        if (glitch) check(cap == expv, "R8", "value with in-bit glitches", int'(cap), int'(expv));
        if (poke) check(oe_clks == oe0, "R11", "pad drive clocks after ignored load", oe_clks - oe0, 0);
        if (gap > 0) check(n_to == to0, "R10", "timeouts during long gap", n_to - to0, 0);
    endtask

    task automatic tx_xfer(input bit word, input logic [15:0] val, input int period, input int phase);
        int nb, d0, lo, hi;
        bit b;
        logic [15:0] got, expv;
        nb  = word ? 16 : 8;
        d0  = n_txd;
        got = '0;
        repeat (phase) @(negedge clk);
        tx_word = word;
        tx_data = val;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = nb - 1; i >= 0; i--) begin
            host_tx_bit(period, b, lo, hi);
            got = {got[14:0], b};
            if (val[i]) begin
                check(lo == 0, "R6", "low drive clocks on a one", lo, 0);
                check(hi == 8, "R2 R6", "speedup clocks on a one", hi, 8);
            end else begin
                check(lo == 104, "R2 R5", "low drive clocks on a zero", lo, 104);
                check(hi == 0, "R5", "high drive clocks on a zero", hi, 0);
            end
        end
        repeat (4) @(negedge clk);
        expv = word ? val : {8'h00, val[7:0]};
        check(got == expv, "R7", "value seen by host", int'(got), int'(expv));
        check(n_txd == d0 + 1, "R7", "tx_done pulses", n_txd - d0, 1);
        check(!busy, "R7", "busy after transmit", int'(busy), 0);
    endtask

    function automatic logic [7:0] pick_byte(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h80;
            3: return 8'h01;
            default: return 8'((i * 37 + 5) & 255);
        endcase
    endfunction

    initial begin
        int rv0, to0, dly;
        repeat (5) @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        check(!pad_oe, "R1", "pad_oe after reset", int'(pad_oe), 0);
        check(!busy, "R1", "busy after reset", int'(busy), 0);
        check(!rx_valid && !tx_done && !timeout, "R1", "strobes after reset",
              int'(rx_valid) + int'(tx_done) + int'(timeout), 0);

        // Receive sweep: phases, two periods, glitches, one long gap, one ignored load.
        for (int i = 0; i < 28; i++)
            rx_xfer(1'b0, {8'h00, pick_byte(i)}, (i % 2 == 0) ? 18 : 20, i % 8,
                    (i % 3 == 0), (i == 6) ? 3840 : 0, (i == 5));
        rx_xfer(1'b1, 16'h8001, 18, 3, 1'b1, 0, 1'b0);
        rx_xfer(1'b1, 16'h5AA5, 20, 6, 1'b0, 0, 1'b1);
        rx_xfer(1'b1, 16'hF00F, 18, 1, 1'b0, 3840, 1'b0);

        // Transmit sweep.
        for (int i = 0; i < 28; i++)
            tx_xfer(1'b0, {8'h00, pick_byte(i)}, (i % 2 == 0) ? 18 : 20, i % 8);
        tx_xfer(1'b1, 16'hC003, 18, 2);
        tx_xfer(1'b1, 16'h1234, 20, 5);
        tx_xfer(1'b1, 16'hFFFF, 18, 7);

        // Both strobes together: transmit wins (R11).
        tx_word  = 1'b0;
        tx_data  = 16'h00A5;
        rx_word  = 1'b0;
        @(negedge clk);
        tx_load  = 1'b1;
        rx_start = 1'b1;
        @(negedge clk);
        tx_load  = 1'b0;
        rx_start = 1'b0;
        @(negedge clk);
        check(busy, "R11", "busy after simultaneous strobes", int'(busy), 1);
        begin
            logic [7:0] got;
            int lo, hi, d0;
            bit b;
            d0 = n_txd;
            for (int i = 7; i >= 0; i--) begin
                host_tx_bit(18, b, lo, hi);
                got = {got[6:0], b};
            end
            repeat (4) @(negedge clk);
            check(got == 8'hA5 && n_txd == d0 + 1, "R11", "transmit chosen over receive",
                  int'(got), 165);
        end

        // Host goes quiet after three bits (R9).
        rv0 = n_rxv;
        to0 = n_to;
        rx_word  = 1'b0;
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        repeat (3) @(negedge clk);
        host_rx_bit(1'b1, 18, 1'b0);
        host_rx_bit(1'b0, 18, 1'b0);
        host_rx_bit(1'b1, 18, 1'b0);
        repeat (4800) @(negedge clk);
        dly = to_cyc - edge_cyc;
        check(n_to == to0 + 1, "R9", "timeout pulses", n_to - to0, 1);
        check(dly >= 4096 && dly <= 4112, "R9", "clocks from last edge to timeout", dly, 4100);
        check(n_rxv == rv0, "R9", "rx_valid after abort", n_rxv - rv0, 0);
        check(!busy, "R9", "busy after abort", int'(busy), 0);

        // Recovery after an abort.
        rx_xfer(1'b0, 16'h003C, 18, 4, 1'b0, 0, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule